// File: doc/BRIEF.md
# Group-Test Defect Map Builder

This block builds a good/bad map for a square array of `K*K` reconfigurable components. The components are never tested one at a time. A run applies a fixed series of tilings. Each tiling splits the array into `K` groups of `K` components, and each group is configured as one test circuit. The block receives one result per group and keeps per-component state. At the end it reports a bitmap with one bit per component, where a set bit means the component is usable.

A run has two phases, and neither depends on any result. In the screening phase, the test circuits report defect counts that are exact only up to a threshold; a larger count is reported as an overflow flag. Each component adds the counts of every circuit it sat in to an integer score. A component whose score is above a limit is dropped. In the location phase, a circuit that reports zero defects clears every surviving member. Any component that is never cleared is reported bad. For a low-defect-rate run, set the limit to its maximum so that screening drops nothing.

The grouping rule uses component index `i = r*K + c` (row `r`, column `c`) and a pattern number `p`. Pattern 0 groups the array by row. For `p >= 1`, the group is `(c + (p-1)*r) mod K`. With `K` prime, these are the `K+1` directions of a modular grid, and any two components share exactly one group across the full set of patterns.

Top module: `dmap_top`

## Requirements
- R1: After reset, `res_ready`, `done` and every bit of `good_map` are 0.
- R2: A `start` pulse clears all scores and good marks, captures `score_limit`, and raises `res_ready` in the next cycle. It restarts a run that is already in progress.
- R3: A run accepts exactly `SCR_TILES*K` screening results and then `LOC_TILES*K` location results, one per cycle where `res_valid` and `res_ready` are both high. In the cycle after the last accepted result, `done` is high for one cycle and `res_ready` is 0.
- R4: Within each phase, tiling `t` uses pattern `p = t mod (K+1)`. Results arrive in group order 0..K-1. Component `i = r*K + c` belongs to group `r` when `p = 0`, and to group `(c + (p-1)*r) mod K` otherwise.
- R5: During screening, each member's score adds `THRESH+1` when `res_over` is 1 or `res_count > THRESH`, and adds `res_count` otherwise. The score saturates at `2^SCORE_W - 1`.
- R6: A component whose final screening score is above the captured limit is never marked good.
- R7: During location, a result with `res_count == 0` and `res_over == 0` marks every member whose score is within the limit as good. Any other result marks nothing. Screening results never mark anything good.
- R8: `good_map` bit `i` is the good mark of component `i`. It stays unchanged from the end of a run until the next `start`.
- R9: `res_valid` has no effect while `res_ready` is 0, and cycles with `res_valid` low consume no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Synchronous run start / clear |
| score_limit | input | SCORE_W | Highest screening score that still survives, captured at start |
| res_valid | input | 1 | A group result is present |
| res_ready | output | 1 | The block is in a run and accepts results |
| res_count | input | CNT_W | Defect count reported by the current test circuit |
| res_over | input | 1 | The test circuit's count went past its threshold |
| done | output | 1 | One-cycle pulse after the last result of a run |
| good_map | output | K*K | Good bit per component, bit index r*K+c |

## Verification
A wrong tiling, group or phase counter puts the wrong results into the wrong components. It also moves the final `done` pulse by whole cycles, so the bench sees it at the end of the affected run. A corrupted score or survivor decision is not visible until the map appears at `done`. Comparing every bit of the map against a model built from the grouping formula shows exactly which component went wrong. A stray good mark shows up at the latest at that comparison; the map is also checked to stay stable afterwards.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SCREEN = 2'd1,
        PH_LOCATE = 2'd2
    } phase_e;

    // Group that component (r,c) joins under pattern p of a k-by-k array.
    function automatic int unsigned group_of(input int unsigned r,
                                             input int unsigned c,
                                             input int unsigned p,
                                             input int unsigned k);
        if (p == 0) return r;
        return (c + (p - 1) * r) % k;
    endfunction

endpackage

// File: rtl/dmap_seq.sv
module dmap_seq
    import dmap_pkg::*;
#(
    parameter int K         = 5,
    parameter int SCR_TILES = 6,
    parameter int LOC_TILES = 6,
    localparam int PAT_W    = $clog2(K + 1),
    localparam int GRP_W    = $clog2(K),
    localparam int MAXT     = (SCR_TILES > LOC_TILES) ? SCR_TILES : LOC_TILES,
    localparam int TILE_W   = $clog2(MAXT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             res_valid,
    output logic             res_ready,
    output logic             accept,
    output logic             locate,
    output logic [PAT_W-1:0] pat,
    output logic [GRP_W-1:0] grp,
    output logic             done
);

    typedef struct packed {
        phase_e              phase;
        logic [TILE_W-1:0]   tile;
        logic [PAT_W-1:0]    pat;
        logic [GRP_W-1:0]    grp;
        logic                done;
    } seq_s;

    seq_s q, d;
    logic take;
    logic [TILE_W-1:0] last_tile;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        take      = (q.phase != PH_IDLE) && res_valid;
        last_tile = (q.phase == PH_SCREEN) ? TILE_W'(SCR_TILES - 1)
                                           : TILE_W'(LOC_TILES - 1);
        if (start) begin
            d.phase = PH_SCREEN;
            d.tile  = '0;
            d.pat   = '0;
            d.grp   = '0;
        end else if (take) begin
            if (q.grp == GRP_W'(K - 1)) begin
                d.grp = '0;
                if (q.tile == last_tile) begin
                    d.tile = '0;
                    d.pat  = '0;
                    if (q.phase == PH_SCREEN) begin
                        d.phase = PH_LOCATE;
                    end else begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end
                end else begin
                    d.tile = q.tile + 1'b1;
                    d.pat  = (q.pat == PAT_W'(K)) ? '0 : q.pat + 1'b1;
                end
            end else begin
                d.grp = q.grp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.tile  <= '0;
            q.pat   <= '0;
            q.grp   <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign res_ready = (q.phase != PH_IDLE);
    assign accept    = take && !start;
    assign locate    = (q.phase == PH_LOCATE);
    assign pat       = q.pat;
    assign grp       = q.grp;
    assign done      = q.done;

endmodule

// File: rtl/dmap_cell.sv
module dmap_cell
    import dmap_pkg::*;
#(
    parameter int K       = 5,
    parameter int ROW     = 0,
    parameter int COL     = 0,
    parameter int SCORE_W = 5,
    parameter int CNT_W   = 3,
    parameter int THRESH  = 3,
    localparam int PAT_W  = $clog2(K + 1),
    localparam int GRP_W  = $clog2(K)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               accept,
    input  logic               locate,
    input  logic [PAT_W-1:0]   pat,
    input  logic [GRP_W-1:0]   grp,
    input  logic [CNT_W-1:0]   res_count,
    input  logic               res_over,
    input  logic [SCORE_W-1:0] limit,
    output logic               good
);

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        logic               good;
    } cell_s;

    cell_s q, d;
    logic               member;
    logic               clean;
    logic [SCORE_W-1:0] inc;
    logic [SCORE_W:0]   sum;

    always_comb begin
        d      = q;
        member = (group_of(ROW, COL, int'(pat), K) == int'(grp));
        clean  = (res_count == '0) && !res_over;
        inc    = (res_over || (res_count > CNT_W'(THRESH))) ? SCORE_W'(THRESH + 1)
                                                           : SCORE_W'(res_count);
        sum    = {1'b0, q.score} + {1'b0, inc};
        if (start) begin
            d.score = '0;
            d.good  = 1'b0;
        end else if (accept && member) begin
            if (!locate) begin
                d.score = sum[SCORE_W] ? '1 : sum[SCORE_W-1:0];
            end else if (clean && (q.score <= limit)) begin
                d.good = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.score <= '0;
            q.good  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign good = q.good;

endmodule

// File: rtl/dmap_top.sv
module dmap_top
    import dmap_pkg::*;
#(
    parameter int K         = 5,
    parameter int SCR_TILES = 6,
    parameter int LOC_TILES = 6,
    parameter int SCORE_W   = 5,
    parameter int CNT_W     = 3,
    parameter int THRESH    = 3,
    localparam int N        = K * K,
    localparam int PAT_W    = $clog2(K + 1),
    localparam int GRP_W    = $clog2(K)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SCORE_W-1:0] score_limit,
    input  logic               res_valid,
    output logic               res_ready,
    input  logic [CNT_W-1:0]   res_count,
    input  logic               res_over,
    output logic               done,
    output logic [N-1:0]       good_map
);

    typedef struct packed {
        logic [SCORE_W-1:0] limit;
    } top_s;

    top_s q, d;
    logic             accept;
    logic             locate;
    logic [PAT_W-1:0] pat;
    logic [GRP_W-1:0] grp;

    always_comb begin
        d = q;
        if (start) d.limit = score_limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.limit <= '0;
        else        q <= d;
    end

    dmap_seq #(
        .K(K), .SCR_TILES(SCR_TILES), .LOC_TILES(LOC_TILES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .res_valid(res_valid),
        .res_ready(res_ready), .accept(accept), .locate(locate),
        .pat(pat), .grp(grp), .done(done)
    );

    for (genvar r = 0; r < K; r++) begin : g_row
        for (genvar c = 0; c < K; c++) begin : g_col
            dmap_cell #(
                .K(K), .ROW(r), .COL(c), .SCORE_W(SCORE_W),
                .CNT_W(CNT_W), .THRESH(THRESH)
            ) u_cell (
                .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
                .locate(locate), .pat(pat), .grp(grp), .res_count(res_count),
                .res_over(res_over), .limit(q.limit), .good(good_map[r*K + c])
            );
        end
    end

endmodule

// File: rtl/dmap_checker.sv
module dmap_checker #(
    parameter int N = 25
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         res_ready,
    input logic         done,
    input logic [N-1:0] good_map
);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_ready);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (good_map == '0) && res_ready);

    assert_map_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_ready && !start) |=> $stable(good_map));

    assert_marks_only_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ready && !start) |=> ((good_map & $past(good_map)) == $past(good_map)));

endmodule

bind dmap_top dmap_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready),
    .done(done), .good_map(good_map)
);

// File: tb/sim_dmap_top.sv
module sim_dmap_top;

    localparam int K       = 5;
    localparam int N       = K * K;
    localparam int SCR     = 6;
    localparam int LOC     = 6;
    localparam int SCORE_W = 4;
    localparam int CNT_W   = 3;
    localparam int THRESH  = 3;
    localparam int SMAX    = (1 << SCORE_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [SCORE_W-1:0] score_limit = '0;
    logic               res_valid = 1'b0;
    logic               res_ready;
    logic [CNT_W-1:0]   res_count = '0;
    logic               res_over = 1'b0;
    logic               done;
    logic [N-1:0]       good_map;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    dmap_top #(
        .K(K), .SCR_TILES(SCR), .LOC_TILES(LOC), .SCORE_W(SCORE_W),
        .CNT_W(CNT_W), .THRESH(THRESH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .score_limit(score_limit),
        .res_valid(res_valid), .res_ready(res_ready), .res_count(res_count),
        .res_over(res_over), .done(done), .good_map(good_map)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int grp_of(int r, int c, int p);
        if (p == 0) return r;
        return (c + (p - 1) * r) % K;
    endfunction

    // Count of defective members of group g under pattern p.
    function automatic int defects_in(logic [N-1:0] mask, int p, int g);
        int n = 0;
        for (int i = 0; i < N; i++)
            if (mask[i] && grp_of(i / K, i % K, p) == g) n++;
        return n;
    endfunction

    task automatic do_start(input logic [SCORE_W-1:0] lim);
        @(negedge clk);
        score_limit = lim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(res_ready == 1'b1, "R2 ready after start", 64'(res_ready), 64'd1);
        check(good_map == '0, "R2 map cleared", 64'(good_map), 64'd0);
    endtask

    task automatic drive_one(input int n, input int gap_seed);
        if (gap_seed % 3 == 2) begin
            // R9: an idle cycle with garbage data must consume nothing
            res_valid = 1'b0;
            res_count = '1;
            res_over  = 1'b1;
            @(negedge clk);
        end
        res_valid = 1'b1;
        res_over  = (n > THRESH);
        res_count = (n > THRESH) ? CNT_W'(gap_seed % 8) : CNT_W'(n);
        @(negedge clk);
    endtask

    // One whole run: screening on mask ms, location on mask ml.
    task automatic run_case(input logic [N-1:0] ms, input logic [N-1:0] ml,
                            input logic [SCORE_W-1:0] lim, input string name);
        int score [N];
        logic [N-1:0] exp_map;
        for (int i = 0; i < N; i++) score[i] = 0;
        exp_map = '0;
        do_start(lim);
        for (int t = 0; t < SCR; t++) begin
            for (int g = 0; g < K; g++) begin
                int n = defects_in(ms, t % (K + 1), g);
                int inc = (n > THRESH) ? THRESH + 1 : n;
                for (int i = 0; i < N; i++)
                    if (grp_of(i / K, i % K, t % (K + 1)) == g) begin
                        score[i] = score[i] + inc;
                        if (score[i] > SMAX) score[i] = SMAX;
                    end
                drive_one(n, t + g);
            end
        end
        for (int t = 0; t < LOC; t++) begin
            for (int g = 0; g < K; g++) begin
                int n = defects_in(ml, t % (K + 1), g);
                if (n == 0)
                    for (int i = 0; i < N; i++)
                        if (grp_of(i / K, i % K, t % (K + 1)) == g && score[i] <= int'(lim))
                            exp_map[i] = 1'b1;
                drive_one(n, t * 2 + g);
            end
        end
        res_valid = 1'b0;
        check(done == 1'b1, {"R3 done pulse ", name}, 64'(done), 64'd1);
        check(res_ready == 1'b0, {"R3 ready low ", name}, 64'(res_ready), 64'd0);
        check(good_map == exp_map, {"R4 R5 R6 R7 map ", name}, 64'(good_map), 64'(exp_map));
        @(negedge clk);
        check(done == 1'b0, {"R3 done single ", name}, 64'(done), 64'd0);
        res_valid = 1'b1;
        res_count = '0;
        @(negedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        check(good_map == exp_map, {"R8 R9 map held ", name}, 64'(good_map), 64'(exp_map));
    endtask

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2345;
        #1;
        check(res_ready == 1'b0 && done == 1'b0 && good_map == '0, "R1 reset state",
              {res_ready, done, 62'(good_map)}, 64'd0);
        #6;
        rst_n = 1'b1;

        // R9: valid while idle is ignored
        @(negedge clk);
        res_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(res_ready == 1'b0 && done == 1'b0, "R9 idle valid ignored",
              {res_ready, done}, 64'd0);
        res_valid = 1'b0;

        run_case('0, '0, '0, "all pass limit0");
        run_case(N'(1) << 7, N'(1) << 7, SCORE_W'(SMAX), "single defect");
        run_case(N'(3) << 11, '0, '0, "screen discards");

        // R2: abandon a run part-way, then a fresh run must be unaffected
        do_start('0);
        for (int j = 0; j < 7; j++) drive_one(5, j);
        res_valid = 1'b0;
        run_case('0, '0, '0, "restart after partial");

        // R5: saturation of the score
        run_case('1, '0, SCORE_W'(SMAX - 1), "saturated discarded");
        run_case('1, '0, SCORE_W'(SMAX), "saturated kept at max");

        for (int k = 0; k < 8; k++) begin
            logic [N-1:0] m;
            m = '0;
            for (int b = 0; b < N; b++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                m[b] = (lfsr[3:0] < 4'd3);
            end
            run_case(m, m, SCORE_W'(k * 2), $sformatf("random %0d", k));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule